// File: doc/BRIEF.md
# System Bus Link Connect/Disconnect Controller

This block sits on the chipset side of a point-to-point processor bus. It decides when the bus to the processor may be released while the processor is idle in a low-power state, and when the bus must be re-established. It watches decoded special cycles from the processor (Stop Grant and Connect), a probe-pending request from the coherency logic, the processor's ready handshake and the stop-clock level. It drives the connect request, the forward-clock reset, a one-cycle forward-clock-enable strobe and two status flags.

A release starts only after a Stop Grant cycle has been seen, or after the probe service that caused the current connection has finished, and never while a probe is pending. The release finishes when the processor drops its ready line. A reconnect raises the forward-clock reset and waits for the processor to raise ready. It then drops the forward-clock reset and counts a fixed number of clock cycles (three by default) before the link is declared up. A status flag records whether the current connection exists for probe service or for a wake event. A probe-caused connection is released again as soon as the probe traffic drains.

Top module: `bus_link_ctrl`

## Requirements
- R1: After the asynchronous reset, connect_o=1, clkfwdrst_o=0, fwd_clk_en_o=0, disconnected_o=0, link_up_o=1 and probe_conn_o=0.
- R2: While the link is up, a Stop Grant cycle pulse on sg_cycle_i is recorded on the next edge. From the edge after that, the link starts to release (connect_o and link_up_o go to 0) on the first edge where probe_req_i is 0. While probe_req_i is 1 the link stays up.
- R3: After connect_o drops, disconnected_o goes to 1 on the edge at which procrdy_i is sampled 0, and not before.
- R4: While disconnected, a reconnect cause raises clkfwdrst_o and connect_o on the next edge. clkfwdrst_o stays 1 until the edge at which procrdy_i is sampled 1, and it falls on that edge.
- R5: fwd_clk_en_o is a one-cycle pulse asserted FWD_DELAY (default 3) edges after clkfwdrst_o falls. link_up_o rises on the same edge.
- R6: A connection caused by probe_req_i sets probe_conn_o=1. Once probe_req_i is 0 on an edge with the link up, the link starts to release without any Stop Grant cycle.
- R7: A probe_req_i sampled 1 while the release is waiting for procrdy_i to drop is latched. disconnected_o is then 1 for exactly one cycle before clkfwdrst_o rises, even if probe_req_i has returned to 0.
- R8: While disconnected, any change of stpclk_i or a connect_cycle_i pulse starts a wake reconnect, with probe_conn_o=0. A wake connection is released only after a new Stop Grant cycle. A change of stpclk_i or a connect_cycle_i pulse seen while the release is still waiting for procrdy_i is latched and serviced the same way.
- R9: A falling edge of stpclk_i while the link is up clears any recorded Stop Grant cycle and the probe-service flag, so the link stays up with no probe pending.
- R10: sys_reset_i sampled 1 on an edge puts the controller in its reset state (values of R1) from any state, cancels a release in progress and clears all recorded cycles and latched requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_reset_i | input | 1 | Synchronous processor reset level |
| sg_cycle_i | input | 1 | Decoded Stop Grant special cycle, one-cycle pulse |
| connect_cycle_i | input | 1 | Decoded Connect special cycle, one-cycle pulse |
| probe_req_i | input | 1 | A probe is pending for the processor |
| procrdy_i | input | 1 | Processor ready handshake |
| stpclk_i | input | 1 | Stop-clock request level |
| connect_o | output | 1 | Bus connect request to the processor |
| clkfwdrst_o | output | 1 | Forward-clock reset |
| fwd_clk_en_o | output | 1 | One-cycle strobe: forward clocks restart |
| disconnected_o | output | 1 | Link is fully disconnected |
| link_up_o | output | 1 | Link is connected and usable |
| probe_conn_o | output | 1 | Current connection exists for probe service |

## Verification
Directed sequences drive a Stop Grant release, then a probe reconnect. They then drive a probe that arrives during the release, a stop-clock wake, a Connect-cycle wake and a synchronous reset in the middle of a release. Together these separate the release gating by probe and by Stop Grant history, the latched-request path and the wake-versus-probe status. Random stimulus then toggles stop clock, ready, probes and special cycles at mixed rates. Every output is compared each cycle with a bench model of the requirements. This exposes any off-by-one in the forward-clock delay and any ordering fault between a cause and the handshake.

// File: rtl/bus_link_pkg.sv
package bus_link_pkg;
  typedef enum logic [2:0] {
    LNK_UP      = 3'd0,
    LNK_DRAIN   = 3'd1,
    LNK_DOWN    = 3'd2,
    LNK_RST     = 3'd3,
    LNK_RDYWAIT = 3'd4,
    LNK_FWDDLY  = 3'd5
  } link_state_e;
endpackage

// File: rtl/bus_link_timer.sv
module bus_link_timer #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !run_i)    cnt_q <= '0;
    else if (!done_o)            cnt_q <= cnt_q + 1'b1;
    else                         cnt_q <= '0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);  // R5
endmodule

// File: rtl/bus_link_fsm.sv
module bus_link_fsm
  import bus_link_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sys_reset_i,
  input  logic        sg_cycle_i,
  input  logic        connect_cycle_i,
  input  logic        probe_req_i,
  input  logic        procrdy_i,
  input  logic        stpclk_i,
  input  logic        dly_done_i,
  output link_state_e state_o,
  output logic        probe_conn_o,
  output logic        fwd_strobe_o
);
  link_state_e state_q, state_d;
  logic stp_q, sg_seen_q, sg_seen_d, probe_conn_q, probe_conn_d;
  logic probe_pend_q, probe_pend_d, wake_pend_q, wake_pend_d, strobe_q;
  logic stp_edge, stp_fall, probe_cause, wake_cause, release_ok;

  assign stp_edge    = stpclk_i ^ stp_q;
  assign stp_fall    = stp_q & ~stpclk_i;
  assign probe_cause = probe_req_i | probe_pend_q;
  assign wake_cause  = stp_edge | connect_cycle_i | wake_pend_q;
  assign release_ok  = ~probe_req_i & ~stp_fall & (sg_seen_q | probe_conn_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LNK_UP:      if (release_ok) state_d = LNK_DRAIN;
      LNK_DRAIN:   if (!procrdy_i) state_d = LNK_DOWN;
      LNK_DOWN:    if (probe_cause || wake_cause) state_d = LNK_RST;
      LNK_RST:     state_d = LNK_RDYWAIT;
      LNK_RDYWAIT: if (procrdy_i) state_d = LNK_FWDDLY;
      LNK_FWDDLY:  if (dly_done_i) state_d = LNK_UP;
      default:     state_d = LNK_UP;
    endcase
  end

  always_comb begin
    sg_seen_d    = (state_q == LNK_UP) & (sg_seen_q | sg_cycle_i) & ~stp_fall;
    probe_pend_d = (state_q == LNK_DRAIN) & (probe_pend_q | probe_req_i);
    wake_pend_d  = (state_q == LNK_DRAIN) & (wake_pend_q | stp_edge | connect_cycle_i);
    probe_conn_d = probe_conn_q;
    if (state_q == LNK_DOWN && (probe_cause || wake_cause))
      probe_conn_d = probe_cause & ~wake_cause;
    else if (state_q == LNK_UP && stp_fall)
      probe_conn_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= LNK_UP;
      stp_q        <= 1'b0;
      sg_seen_q    <= 1'b0;
      probe_conn_q <= 1'b0;
      probe_pend_q <= 1'b0;
      wake_pend_q  <= 1'b0;
      strobe_q     <= 1'b0;
    end else begin
      stp_q <= stpclk_i;
      if (sys_reset_i) begin
        state_q      <= LNK_UP;
        sg_seen_q    <= 1'b0;
        probe_conn_q <= 1'b0;
        probe_pend_q <= 1'b0;
        wake_pend_q  <= 1'b0;
        strobe_q     <= 1'b0;
      end else begin
        state_q      <= state_d;
        sg_seen_q    <= sg_seen_d;
        probe_conn_q <= probe_conn_d;
        probe_pend_q <= probe_pend_d;
        wake_pend_q  <= wake_pend_d;
        strobe_q     <= (state_q == LNK_FWDDLY) & dly_done_i;
      end
    end
  end

  assign state_o      = state_q;
  assign probe_conn_o = probe_conn_q;
  assign fwd_strobe_o = strobe_q;

  AST_DRAIN_NO_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == LNK_DRAIN) |-> $past(!probe_req_i));  // R2
  AST_DOWN_AFTER_RDY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == LNK_DOWN) |-> $past(!procrdy_i));  // R3
  AST_PEND_SERVICED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LNK_DOWN && probe_pend_q && !sys_reset_i) |=> state_q == LNK_RST);  // R7
  AST_SYNC_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_i |=> (state_q == LNK_UP && !probe_conn_q && !sg_seen_q));  // R10
endmodule

// File: rtl/bus_link_ctrl.sv
module bus_link_ctrl
  import bus_link_pkg::*;
#(
  parameter int unsigned FWD_DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_reset_i,
  input  logic sg_cycle_i,
  input  logic connect_cycle_i,
  input  logic probe_req_i,
  input  logic procrdy_i,
  input  logic stpclk_i,
  output logic connect_o,
  output logic clkfwdrst_o,
  output logic fwd_clk_en_o,
  output logic disconnected_o,
  output logic link_up_o,
  output logic probe_conn_o
);
  link_state_e state;
  logic dly_done, strobe, pconn;

  bus_link_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sys_reset_i     (sys_reset_i),
    .sg_cycle_i      (sg_cycle_i),
    .connect_cycle_i (connect_cycle_i),
    .probe_req_i     (probe_req_i),
    .procrdy_i       (procrdy_i),
    .stpclk_i        (stpclk_i),
    .dly_done_i      (dly_done),
    .state_o         (state),
    .probe_conn_o    (pconn),
    .fwd_strobe_o    (strobe)
  );

  bus_link_timer #(.DELAY(FWD_DELAY)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sys_reset_i),
    .run_i  (state == LNK_FWDDLY),
    .done_o (dly_done)
  );

  assign connect_o      = (state != LNK_DRAIN) && (state != LNK_DOWN);
  assign clkfwdrst_o    = (state == LNK_RST) || (state == LNK_RDYWAIT);
  assign disconnected_o = (state == LNK_DOWN);
  assign link_up_o      = (state == LNK_UP);
  assign fwd_clk_en_o   = strobe;
  assign probe_conn_o   = pconn;

  AST_FWDRST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clkfwdrst_o) |-> $past(procrdy_i || sys_reset_i));  // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_clk_en_o |=> !fwd_clk_en_o);  // R5
  AST_STROBE_LINK_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_clk_en_o |-> (link_up_o && !clkfwdrst_o));  // R5
endmodule

// File: tb/tb_bus_link_ctrl.sv
module tb_bus_link_ctrl;
  import bus_link_pkg::*;
  localparam int unsigned DLY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic srst = 0, sg = 0, cc = 0, pr = 0, rdy = 1, stp = 0;
  logic connect_o, clkfwdrst_o, fwd_o, disc_o, up_o, pconn_o;
  int unsigned n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_link_ctrl #(.FWD_DELAY(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_reset_i(srst), .sg_cycle_i(sg),
    .connect_cycle_i(cc), .probe_req_i(pr), .procrdy_i(rdy), .stpclk_i(stp),
    .connect_o(connect_o), .clkfwdrst_o(clkfwdrst_o), .fwd_clk_en_o(fwd_o),
    .disconnected_o(disc_o), .link_up_o(up_o), .probe_conn_o(pconn_o)
  );

  // Requirement model
  link_state_e m_st;
  bit m_stq, m_sg, m_pc, m_pp, m_wp, m_fwd;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = LNK_UP; m_stq = 0; m_sg = 0; m_pc = 0; m_pp = 0; m_wp = 0; m_fwd = 0; m_cnt = 0;
    end else begin
      bit edge_s, fall_s, pcause, wcause, go;
      link_state_e ns;
      edge_s = (stp != m_stq);
      fall_s = m_stq && !stp;
      pcause = pr || m_pp;
      wcause = edge_s || cc || m_wp;
      m_stq = stp;
      if (srst) begin
        m_st = LNK_UP; m_sg = 0; m_pc = 0; m_pp = 0; m_wp = 0; m_fwd = 0; m_cnt = 0;
      end else begin
        ns = m_st;
        m_fwd = 0;
        case (m_st)
          LNK_UP: begin
            if (!pr && !fall_s && (m_sg || m_pc)) ns = LNK_DRAIN;
            if (fall_s) m_pc = 0;
            m_sg = (m_sg || sg) && !fall_s;
          end
          LNK_DRAIN: begin
            m_sg = 0;
            m_pp = m_pp || pr;
            m_wp = m_wp || edge_s || cc;
            if (!rdy) ns = LNK_DOWN;
          end
          LNK_DOWN: begin
            go = pcause || wcause;
            if (go) begin m_pc = pcause && !wcause; ns = LNK_RST; end
            m_pp = 0; m_wp = 0;
          end
          LNK_RST: ns = LNK_RDYWAIT;
          LNK_RDYWAIT: if (rdy) begin ns = LNK_FWDDLY; m_cnt = 0; end
          default: begin
            if (m_cnt == DLY - 1) begin ns = LNK_UP; m_fwd = 1; end
            m_cnt++;
          end
        endcase
        if (m_st != LNK_UP) m_sg = 0;
        if (m_st != LNK_DRAIN && m_st != LNK_DOWN) begin m_pp = 0; m_wp = 0; end
        m_st = ns;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R2 connect_o", connect_o, (m_st != LNK_DRAIN && m_st != LNK_DOWN));
    chk("R4 clkfwdrst_o", clkfwdrst_o, (m_st == LNK_RST || m_st == LNK_RDYWAIT));
    chk("R3 disconnected_o", disc_o, m_st == LNK_DOWN);
    chk("R5 link_up_o", up_o, m_st == LNK_UP);
    chk("R5 fwd_clk_en_o", fwd_o, m_fwd);
    chk("R6 probe_conn_o", pconn_o, m_pc);
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_reconnect();
    rdy = 1;
    tick(2 + DLY);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    chk("R1 connect", connect_o, 1); chk("R1 clkfwdrst", clkfwdrst_o, 0);
    chk("R1 fwd", fwd_o, 0); chk("R1 disc", disc_o, 0);
    chk("R1 up", up_o, 1); chk("R1 pconn", pconn_o, 0);

    stp = 1; tick();
    sg = 1; tick(); sg = 0;
    chk("R2 still up after record", up_o, 1);
    tick();
    chk("R2 release started", connect_o, 0);
    tick();
    chk("R3 waits for rdy low", disc_o, 0);
    rdy = 0; tick();
    chk("R3 disconnected", disc_o, 1);
    pr = 1; tick();
    chk("R4 clkfwdrst rises", clkfwdrst_o, 1); chk("R4 connect rises", connect_o, 1);
    tick(2);
    chk("R4 clkfwdrst held", clkfwdrst_o, 1);
    rdy = 1; tick();
    chk("R4 clkfwdrst falls", clkfwdrst_o, 0);
    for (int i = 1; i < DLY; i++) begin tick(); chk("R5 no early strobe", fwd_o, 0); end
    tick();
    chk("R5 strobe", fwd_o, 1); chk("R5 link up", up_o, 1); chk("R6 probe conn", pconn_o, 1);
    tick();
    chk("R5 strobe one cycle", fwd_o, 0); chk("R6 held by probe", up_o, 1);
    pr = 0; tick();
    chk("R6 release after probe", connect_o, 0);

    pr = 1; rdy = 0; tick(); pr = 0;
    chk("R7 disconnected one cycle", disc_o, 1);
    tick();
    chk("R7 latched probe reconnect", clkfwdrst_o, 1);
    finish_reconnect();
    chk("R7 up for probe", up_o, 1); chk("R7 probe conn", pconn_o, 1);
    tick();
    chk("R6 release again", connect_o, 0);
    rdy = 0; tick();
    chk("R3 down again", disc_o, 1);

    stp = 0; tick();
    chk("R8 wake reconnect", clkfwdrst_o, 1);
    finish_reconnect();
    chk("R8 wake conn flag", pconn_o, 0); chk("R8 up", up_o, 1);
    tick(10);
    chk("R9 stays up", connect_o, 1);
    stp = 1; tick(6);
    chk("R8 no release without stop grant", up_o, 1);
    pr = 1; sg = 1; tick(); sg = 0; tick(3);
    chk("R2 held by probe", up_o, 1);
    pr = 0; tick();
    chk("R2 release after probe clears", connect_o, 0);
    srst = 1; tick(); srst = 0;
    chk("R10 up", up_o, 1); chk("R10 connect", connect_o, 1); chk("R10 disc", disc_o, 0);
    tick(4);
    chk("R10 history cleared", up_o, 1);

    sg = 1; tick(); sg = 0; tick(2);
    rdy = 0; tick();
    chk("R8 down before connect cycle", disc_o, 1);
    cc = 1; tick(); cc = 0;
    chk("R8 connect cycle wake", clkfwdrst_o, 1);
    finish_reconnect();
    chk("R8 connect cycle not probe", pconn_o, 0);

    for (int i = 0; i < 6000; i++) begin
      sg   = ($urandom % 8) == 0;
      cc   = ($urandom % 40) == 0;
      srst = ($urandom % 600) == 0;
      if (($urandom % 6) == 0) pr = ~pr;
      if (($urandom % 3) == 0) rdy = ~rdy;
      if (($urandom % 50) == 0) stp = ~stp;
      tick();
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial void'($urandom(32'h5eed_0b1e));
endmodule